// File: doc/BRIEF.md
# SPI Register-Access Peripheral with In-Band Wait States

This block is an SPI peripheral (clock idle low, data captured on the rising edge, changed on the falling edge, byte-aligned) that turns each chip-select frame into one register access. The controller first shifts in a four-byte header. The command byte carries the direction and the length, and three address bytes follow with the most significant byte first. When the header is complete the block raises a one-cycle request that carries the address, the length and the direction.

Flow control travels inside the serial stream. Bit 0 of the fourth byte returned on MISO is a ready flag. While that flag is 0 the controller keeps clocking wait bytes, and each wait byte carries a fresh flag. The byte that carries a 1 ends the wait, and the data bytes then follow back to back. Each flag comes from the user `user_ready` input as it stands when the previous byte completes.

Write data leaves as a byte stream, and a separate commit pulse marks that every byte has arrived. Read data enters through a valid/ready stream into a single holding register, and that register must be full before each data byte begins. SPI inputs are synchronised into the system clock, which must run at least eight times faster than SCLK.

Top module: `spi_regacc_periph`

## Requirements
- R1: The command byte is decoded as follows. Bit 7 = 1 selects read and 0 selects write. Bits 5:0 hold the length minus one, giving 1 to 64 bytes. Bit 6 is ignored. The next three bytes form `req_addr[23:16]`, `[15:8]` and `[7:0]`. After the fourth byte, `req_valid` pulses for exactly one cycle with `req_read`, `req_addr` and `req_len` (1..64) valid.
- R2: Header bytes 0 to 2 return 0x00 on MISO. Byte 3 returns 0x00 with the ready flag in bit 0, and the flag equals `user_ready` as sampled when byte 2 completes. If that flag is 1, no wait bytes are inserted.
- R3: After a 0 flag, each following byte returns 0x00 with bit 0 set to `user_ready` as sampled when the previous byte completed. The first byte whose bit 0 is 1 is the last wait byte, and data starts with the next byte.
- R4: In a write, each of the `req_len` data bytes produces one `wr_valid` pulse carrying that byte, in arrival order. Bytes beyond `req_len` produce nothing. MISO returns 0x00 throughout the write data phase.
- R5: `wr_commit` pulses once, after the last write data byte. A write cut short by chip select gives no commit.
- R6: In a read, the data bytes on MISO, MSB first, are the stream bytes in the order they were accepted, `req_len` of them. Bytes clocked beyond `req_len` return 0x00.
- R7: `rd_ready` is high only during a read transaction's wait or data phase while the holding register is empty. Exactly `req_len` bytes are accepted per read.
- R8: If the holding register is empty when a read data byte must start, that byte returns 0x00 and `underrun_err` rises and stays high until reset.
- R9: Raising chip select at any point abandons the transaction. The next frame starts with a new header.
- R10: After reset, `spi_miso`, `req_valid`, `wr_valid`, `wr_commit`, `rd_ready` and `underrun_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Data from the controller |
| spi_miso | output | 1 | Data to the controller |
| user_ready | input | 1 | User side can proceed; source of the ready flag |
| req_valid | output | 1 | One-cycle pulse: header decoded |
| req_read | output | 1 | 1 = read access |
| req_addr | output | 24 | Register address |
| req_len | output | 7 | Transfer length, 1..64 |
| wr_valid | output | 1 | Write data byte valid (one cycle) |
| wr_data | output | 8 | Write data byte |
| wr_commit | output | 1 | All write bytes received |
| rd_valid | input | 1 | Read data byte offered |
| rd_data | input | 8 | Read data byte |
| rd_ready | output | 1 | Holding register can take a byte |
| underrun_err | output | 1 | Sticky read underrun flag |

## Verification
The bench varies the number of wait bytes between zero and three. A design that sampled the flag one byte late, or let a stale flag release the stall, would show a misplaced 1 on MISO and every data byte shifted by one position. It drives transfers at the extremes of length (1 and 64 bytes) and clocks extra bytes past the end. A design with an off-by-one in length would emit a spurious write pulse or a non-zero byte. It aborts a write halfway and then runs a fresh transaction, which catches a design that commits partial writes or keeps stale header state. Finally it starves the read stream, so a design missing the underrun path or clearing the error flag would be caught.

// File: rtl/spiw_pkg.sv
`timescale 1ns/1ps
package spiw_pkg;
  localparam int BYTE_W = 8;
  localparam int RD_BIT = 7;

  typedef enum logic [1:0] {
    PH_HDR  = 2'd0,
    PH_WAIT = 2'd1,
    PH_DATA = 2'd2,
    PH_DONE = 2'd3
  } phase_e;
endpackage

// File: rtl/spiw_sync.sv
`timescale 1ns/1ps
module spiw_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CHAIN_W = W * STAGES;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_n;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_n = d;
    end else begin : g_many
      assign chain_n = {chain_q[CHAIN_W-W-1:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_n;
  end

  assign q = chain_q[CHAIN_W-1 -: W];
endmodule

// File: rtl/spiw_shift.sv
`timescale 1ns/1ps
module spiw_shift
  import spiw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              cs_n_s,
  input  logic              mosi_s,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              cs_act,
  output logic              miso
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic              sclk_q;
  logic [CNT_W-1:0]  bit_q, bit_n;
  logic [BYTE_W-1:0] rxsr_q, rxsr_n;
  logic [BYTE_W-1:0] txsr_q, txsr_n;
  logic [BYTE_W-1:0] rxb_q, rxb_n;
  logic              done_q, done_n;
  logic              miso_q, miso_n;
  logic              rise, fall;

  assign rise   = sclk_s & ~sclk_q;
  assign fall   = ~sclk_s & sclk_q;
  assign cs_act = ~cs_n_s;

  always_comb begin
    bit_n  = bit_q;
    rxsr_n = rxsr_q;
    txsr_n = txsr_q;
    rxb_n  = rxb_q;
    done_n = 1'b0;
    miso_n = miso_q;
    if (cs_n_s) begin
      bit_n  = '0;
      txsr_n = '0;
      miso_n = 1'b0;
    end else begin
      if (rise) begin
        rxsr_n = {rxsr_q[BYTE_W-2:0], mosi_s};
        bit_n  = bit_q + CNT_W'(1);
        if (bit_q == LAST_BIT) begin
          done_n = 1'b1;
          rxb_n  = {rxsr_q[BYTE_W-2:0], mosi_s};
        end
      end
      if (fall) begin
        if (bit_q == '0) begin
          miso_n = tx_byte[BYTE_W-1];
          txsr_n = {tx_byte[BYTE_W-2:0], 1'b0};
        end else begin
          miso_n = txsr_q[BYTE_W-1];
          txsr_n = {txsr_q[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      bit_q  <= '0;
      rxsr_q <= '0;
      txsr_q <= '0;
      rxb_q  <= '0;
      done_q <= 1'b0;
      miso_q <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      bit_q  <= bit_n;
      rxsr_q <= rxsr_n;
      txsr_q <= txsr_n;
      rxb_q  <= rxb_n;
      done_q <= done_n;
      miso_q <= miso_n;
    end
  end

  assign byte_done = done_q;
  assign rx_byte   = rxb_q;
  assign miso      = miso_q;
endmodule

// File: rtl/spiw_ctrl.sv
`timescale 1ns/1ps
module spiw_ctrl
  import spiw_pkg::*;
#(
  parameter int SIZE_BITS  = 6,
  parameter int ADDR_BYTES = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   byte_done,
  input  logic [BYTE_W-1:0]      rx_byte,
  input  logic                   cs_act,
  input  logic                   user_ready,
  input  logic                   rd_valid,
  input  logic [BYTE_W-1:0]      rd_data,
  output logic [BYTE_W-1:0]      tx_byte,
  output logic                   req_valid,
  output logic                   req_read,
  output logic [8*ADDR_BYTES-1:0] req_addr,
  output logic [SIZE_BITS:0]     req_len,
  output logic                   wr_valid,
  output logic [BYTE_W-1:0]      wr_data,
  output logic                   wr_commit,
  output logic                   rd_ready,
  output logic                   underrun_err
);
  localparam int ADDR_W = BYTE_W * ADDR_BYTES;
  localparam int LEN_W  = SIZE_BITS + 1;
  localparam int IDX_W  = $clog2(ADDR_BYTES + 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ADDR_BYTES);
  localparam logic [IDX_W-1:0] IDX_FLAG = IDX_W'(ADDR_BYTES - 1);

  phase_e            ph_q, ph_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [BYTE_W-1:0] cmd_q, cmd_n;
  logic [ADDR_W-1:0] addr_q, addr_n, addr_shift;
  logic              read_q, read_n;
  logic [LEN_W-1:0]  len_q, len_n, dec_len;
  logic [LEN_W-1:0]  left_q, left_n;
  logic [LEN_W-1:0]  fetch_q, fetch_n;
  logic              flag_q, flag_n;
  logic [BYTE_W-1:0] hold_q, hold_n;
  logic              hvld_q, hvld_n;
  logic [BYTE_W-1:0] tx_q, tx_n;
  logic              err_q, err_n;
  logic              reqv_q, reqv_n;
  logic              wrv_q, wrv_n;
  logic [BYTE_W-1:0] wrd_q, wrd_n;
  logic              cmt_q, cmt_n;
  logic              need_load;
  logic              take;
  logic              rdy;

  generate
    if (ADDR_BYTES == 1) begin : g_addr_one
      assign addr_shift = rx_byte;
    end else begin : g_addr_many
      assign addr_shift = {addr_q[ADDR_W-BYTE_W-1:0], rx_byte};
    end
  endgenerate

  assign dec_len = LEN_W'(cmd_q[SIZE_BITS-1:0]) + LEN_W'(1);
  assign rdy     = cs_act && read_q && (ph_q == PH_WAIT || ph_q == PH_DATA)
                   && !hvld_q && (fetch_q != '0);
  assign take    = rd_valid && rdy;

  always_comb begin
    ph_n      = ph_q;
    idx_n     = idx_q;
    cmd_n     = cmd_q;
    addr_n    = addr_q;
    read_n    = read_q;
    len_n     = len_q;
    left_n    = left_q;
    fetch_n   = fetch_q;
    flag_n    = flag_q;
    hold_n    = hold_q;
    hvld_n    = hvld_q;
    tx_n      = tx_q;
    err_n     = err_q;
    reqv_n    = 1'b0;
    wrv_n     = 1'b0;
    wrd_n     = wrd_q;
    cmt_n     = 1'b0;
    need_load = 1'b0;

    if (take) begin
      hold_n  = rd_data;
      hvld_n  = 1'b1;
      fetch_n = fetch_q - LEN_W'(1);
    end

    if (!cs_act) begin
      ph_n    = PH_HDR;
      idx_n   = '0;
      hvld_n  = 1'b0;
      fetch_n = '0;
      flag_n  = 1'b0;
      tx_n    = '0;
    end else if (byte_done) begin
      tx_n = '0;
      unique case (ph_q)
        PH_HDR: begin
          if (idx_q == '0) cmd_n  = rx_byte;
          else             addr_n = addr_shift;
          idx_n = idx_q + IDX_W'(1);
          if (idx_q == IDX_FLAG) begin
            tx_n   = {{(BYTE_W-1){1'b0}}, user_ready};
            flag_n = user_ready;
          end
          if (idx_q == IDX_LAST) begin
            idx_n   = '0;
            reqv_n  = 1'b1;
            read_n  = cmd_q[RD_BIT];
            len_n   = dec_len;
            fetch_n = cmd_q[RD_BIT] ? dec_len : '0;
            if (flag_q) begin
              ph_n      = PH_DATA;
              left_n    = dec_len;
              need_load = cmd_q[RD_BIT];
            end else begin
              ph_n   = PH_WAIT;
              tx_n   = {{(BYTE_W-1){1'b0}}, user_ready};
              flag_n = user_ready;
            end
          end
        end
        PH_WAIT: begin
          if (flag_q) begin
            ph_n      = PH_DATA;
            left_n    = len_q;
            need_load = read_q;
          end else begin
            tx_n   = {{(BYTE_W-1){1'b0}}, user_ready};
            flag_n = user_ready;
          end
        end
        PH_DATA: begin
          left_n = left_q - LEN_W'(1);
          if (!read_q) begin
            wrv_n = 1'b1;
            wrd_n = rx_byte;
          end
          if (left_q == LEN_W'(1)) begin
            ph_n  = PH_DONE;
            cmt_n = !read_q;
          end else begin
            need_load = read_q;
          end
        end
        default: begin
          tx_n = '0;
        end
      endcase

      if (need_load) begin
        if (hvld_q) begin
          tx_n   = hold_q;
          hvld_n = 1'b0;
        end else begin
          err_n = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_HDR;
      idx_q   <= '0;
      cmd_q   <= '0;
      addr_q  <= '0;
      read_q  <= 1'b0;
      len_q   <= '0;
      left_q  <= '0;
      fetch_q <= '0;
      flag_q  <= 1'b0;
      hold_q  <= '0;
      hvld_q  <= 1'b0;
      tx_q    <= '0;
      err_q   <= 1'b0;
      reqv_q  <= 1'b0;
      wrv_q   <= 1'b0;
      wrd_q   <= '0;
      cmt_q   <= 1'b0;
    end else begin
      ph_q    <= ph_n;
      idx_q   <= idx_n;
      cmd_q   <= cmd_n;
      addr_q  <= addr_n;
      read_q  <= read_n;
      len_q   <= len_n;
      left_q  <= left_n;
      fetch_q <= fetch_n;
      flag_q  <= flag_n;
      hold_q  <= hold_n;
      hvld_q  <= hvld_n;
      tx_q    <= tx_n;
      err_q   <= err_n;
      reqv_q  <= reqv_n;
      wrv_q   <= wrv_n;
      wrd_q   <= wrd_n;
      cmt_q   <= cmt_n;
    end
  end

  assign tx_byte      = tx_q;
  assign req_valid    = reqv_q;
  assign req_read     = read_q;
  assign req_addr     = addr_q;
  assign req_len      = len_q;
  assign wr_valid     = wrv_q;
  assign wr_data      = wrd_q;
  assign wr_commit    = cmt_q;
  assign rd_ready     = rdy;
  assign underrun_err = err_q;
endmodule

// File: rtl/spi_regacc_periph.sv
`timescale 1ns/1ps
module spi_regacc_periph
  import spiw_pkg::*;
#(
  parameter int SIZE_BITS   = 6,
  parameter int ADDR_BYTES  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    spi_sclk,
  input  logic                    spi_cs_n,
  input  logic                    spi_mosi,
  output logic                    spi_miso,
  input  logic                    user_ready,
  output logic                    req_valid,
  output logic                    req_read,
  output logic [8*ADDR_BYTES-1:0] req_addr,
  output logic [SIZE_BITS:0]      req_len,
  output logic                    wr_valid,
  output logic [BYTE_W-1:0]       wr_data,
  output logic                    wr_commit,
  input  logic                    rd_valid,
  input  logic [BYTE_W-1:0]       rd_data,
  output logic                    rd_ready,
  output logic                    underrun_err
);
  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  logic [2:0]        pins_s;
  logic              byte_done;
  logic [BYTE_W-1:0] rx_byte;
  logic [BYTE_W-1:0] tx_byte;
  logic              cs_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  spiw_sync #(
    .W       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b010)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     ({spi_sclk, spi_cs_n, spi_mosi}),
    .q     (pins_s)
  );

  spiw_shift u_shift (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .sclk_s    (pins_s[2]),
    .cs_n_s    (pins_s[1]),
    .mosi_s    (pins_s[0]),
    .tx_byte   (tx_byte),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .cs_act    (cs_act),
    .miso      (spi_miso)
  );

  spiw_ctrl #(
    .SIZE_BITS  (SIZE_BITS),
    .ADDR_BYTES (ADDR_BYTES)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .byte_done    (byte_done),
    .rx_byte      (rx_byte),
    .cs_act       (cs_act),
    .user_ready   (user_ready),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .tx_byte      (tx_byte),
    .req_valid    (req_valid),
    .req_read     (req_read),
    .req_addr     (req_addr),
    .req_len      (req_len),
    .wr_valid     (wr_valid),
    .wr_data      (wr_data),
    .wr_commit    (wr_commit),
    .rd_ready     (rd_ready),
    .underrun_err (underrun_err)
  );
endmodule

// File: rtl/spiw_chk.sv
`timescale 1ns/1ps
module spiw_chk #(
  parameter int SIZE_BITS = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [SIZE_BITS:0] req_len,
  input logic               wr_valid,
  input logic               wr_commit,
  input logic               rd_valid,
  input logic               rd_ready,
  input logic               underrun_err
);
  localparam int LEN_MAX = 1 << SIZE_BITS;

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid); // R1
  AST_REQ_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len >= 1 && int'(req_len) <= LEN_MAX)); // R1
  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit); // R5
  AST_COMMIT_NOT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> !req_valid); // R5
  AST_HOLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> !rd_ready); // R7
  AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> !wr_valid); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_err |=> underrun_err); // R8
endmodule

bind spi_regacc_periph spiw_chk #(.SIZE_BITS(SIZE_BITS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_len      (req_len),
  .wr_valid     (wr_valid),
  .wr_commit    (wr_commit),
  .rd_valid     (rd_valid),
  .rd_ready     (rd_ready),
  .underrun_err (underrun_err)
);

// File: tb/spi_regacc_periph_tb.sv
`timescale 1ns/1ps
module spi_regacc_periph_tb;
  localparam real HALF = 40.0;

  logic        clk;
  logic        rst_n;
  logic        spi_sclk, spi_cs_n, spi_mosi, spi_miso;
  logic        user_ready;
  logic        req_valid, req_read;
  logic [23:0] req_addr;
  logic [6:0]  req_len;
  logic        wr_valid, wr_commit;
  logic [7:0]  wr_data;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic        rd_ready, underrun_err;

  int n_chk = 0;
  int n_fail = 0;

  int          mon_req_cnt;
  logic        mon_req_read;
  logic [23:0] mon_req_addr;
  logic [6:0]  mon_req_len;
  logic [7:0]  wr_seen[$];
  int          commit_cnt;
  int          rd_pops;
  logic [7:0]  rsp_q[$];
  bit          rsp_en;
  bit          err_allowed;
  bit          err_flagged;

  spi_regacc_periph u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .user_ready(user_ready),
    .req_valid(req_valid), .req_read(req_read), .req_addr(req_addr),
    .req_len(req_len), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_commit(wr_commit), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_ready(rd_ready), .underrun_err(underrun_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // behavioural observer of the user-side outputs
  always @(negedge clk) begin
    if (req_valid) begin
      mon_req_cnt++;
      mon_req_read = req_read;
      mon_req_addr = req_addr;
      mon_req_len  = req_len;
    end
    if (wr_valid) wr_seen.push_back(wr_data);
    if (wr_commit) commit_cnt++;
    if (underrun_err && !err_allowed && !err_flagged) begin
      err_flagged = 1'b1;
      chk(1'b0, "R8 unexpected underrun", 1, 0);
    end
  end

  // read-stream source
  initial begin
    rd_valid = 1'b0;
    rd_data  = 8'h00;
    forever begin
      @(negedge clk);
      #1;
      if (rsp_en && rd_ready && rsp_q.size() > 0) begin
        rd_valid = 1'b1;
        rd_data  = rsp_q[0];
        @(negedge clk);
        #1;
        void'(rsp_q.pop_front());
        rd_pops++;
        rd_valid = 1'b0;
      end
    end
  end

  task automatic xfer_byte(input logic [7:0] out, output logic [7:0] got);
    for (int b = 7; b >= 0; b--) begin
      spi_mosi = out[b];
      #(HALF);
      got[b] = spi_miso;
      spi_sclk = 1'b1;
      #(HALF);
      spi_sclk = 1'b0;
    end
  endtask

  function automatic logic [7:0] wbyte(input int i, input logic [23:0] a);
    return 8'(8'h11 * (i + 1)) ^ a[7:0];
  endfunction

  function automatic logic [7:0] rbyte(input int i, input logic [23:0] a);
    return 8'(8'h3C + i * 7) ^ a[15:8];
  endfunction

  // one frame: waits = number of 0-flag bytes; abort_at = data bytes before CS rises (-1: none)
  task automatic run_txn(input bit rd, input int len, input logic [23:0] addr,
                         input int waits, input int extra, input int abort_at,
                         input bit junk6);
    logic [7:0] cmd, outb, got, expb;
    int sent, nb, di;
    string tag;
    cmd = {rd, junk6, 6'(len - 1)};
    sent = (abort_at >= 0) ? abort_at : len + extra;
    nb = 4 + waits + sent;
    mon_req_cnt = 0;
    wr_seen.delete();
    commit_cnt = 0;
    rd_pops = 0;
    if (rd && rsp_en)
      for (int i = 0; i < len; i++) rsp_q.push_back(rbyte(i, addr));
    @(negedge clk);
    spi_cs_n = 1'b0;
    #(HALF);
    for (int k = 0; k < nb; k++) begin
      user_ready = (k >= 2 + waits);
      di = k - (4 + waits);
      if (k == 0)      outb = cmd;
      else if (k < 4)  outb = addr[8*(3-k) +: 8];
      else if (di >= 0 && !rd && di < len) outb = wbyte(di, addr);
      else             outb = 8'hA5;
      if (k < 3) begin
        expb = 8'h00; tag = "R2 header byte";
      end else if (k <= 3 + waits) begin
        expb = {7'b0, (k == 3 + waits)};
        tag = (k == 3) ? "R2 flag byte" : "R3 wait byte";
      end else if (di < len) begin
        expb = (rd && rsp_en) ? rbyte(di, addr) : 8'h00;
        tag = rd ? (rsp_en ? "R6 read data" : "R8 underrun data") : "R4 write phase miso";
      end else begin
        expb = 8'h00;
        tag = "R6 beyond length";
      end
      xfer_byte(outb, got);
      chk(got === expb, tag, int'(got), int'(expb));
    end
    user_ready = 1'b0;
    #(HALF);
    spi_cs_n = 1'b1;
    #(HALF * 4);
    chk(mon_req_cnt == 1, "R1 request count", mon_req_cnt, 1);
    chk(mon_req_read == rd, "R1 direction", int'(mon_req_read), int'(rd));
    chk(mon_req_addr == addr, "R1 address", int'(mon_req_addr), int'(addr));
    chk(int'(mon_req_len) == len, "R1 length", int'(mon_req_len), len);
    if (!rd) begin
      int expn;
      expn = (abort_at >= 0) ? abort_at : len;
      chk(wr_seen.size() == expn, "R4 write byte count", wr_seen.size(), expn);
      for (int i = 0; i < wr_seen.size() && i < expn; i++)
        chk(wr_seen[i] == wbyte(i, addr), "R4 write byte value", int'(wr_seen[i]),
            int'(wbyte(i, addr)));
      chk(commit_cnt == ((abort_at < 0) ? 1 : 0), "R5 commit count", commit_cnt,
          (abort_at < 0) ? 1 : 0);
    end else begin
      chk(wr_seen.size() == 0, "R7 no write during read", wr_seen.size(), 0);
      if (rsp_en) chk(rd_pops == len, "R7 bytes fetched", rd_pops, len);
      else        chk(rd_pops == 0, "R8 nothing fetched", rd_pops, 0);
    end
  endtask

  initial begin
    #(190000 * 5);
    n_fail++;
    $display("FAIL watchdog R9 actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    spi_sclk = 1'b0;
    spi_cs_n = 1'b1;
    spi_mosi = 1'b0;
    user_ready = 1'b0;
    rsp_en = 1'b1;
    err_allowed = 1'b0;
    err_flagged = 1'b0;
    mon_req_cnt = 0;
    commit_cnt = 0;
    rd_pops = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(spi_miso == 1'b0, "R10 miso after reset", int'(spi_miso), 0);
    chk(req_valid == 1'b0, "R10 req_valid after reset", int'(req_valid), 0);
    chk(wr_valid == 1'b0 && wr_commit == 1'b0, "R10 write outputs after reset",
        int'({wr_valid, wr_commit}), 0);
    chk(rd_ready == 1'b0, "R10 rd_ready after reset", int'(rd_ready), 0);
    chk(underrun_err == 1'b0, "R10 error after reset", int'(underrun_err), 0);

    run_txn(1'b0, 4, 24'hAABBCC, 3, 0, -1, 1'b0);   // R3 stall then write
    run_txn(1'b1, 4, 24'hAABBCC, 3, 0, -1, 1'b0);   // R6 read after stall
    run_txn(1'b0, 1, 24'h012345, 0, 2, -1, 1'b1);   // R2 no wait, R1 bit 6, R4 extra
    run_txn(1'b1, 64, 24'hF00D01, 1, 2, -1, 1'b0);  // R6 max length
    run_txn(1'b0, 4, 24'h13579B, 2, 0, 2, 1'b0);    // R5 R9 abort mid-write
    run_txn(1'b0, 2, 24'h2468AC, 1, 0, -1, 1'b0);   // R9 fresh header after abort

    rsp_en = 1'b0;
    err_allowed = 1'b1;
    run_txn(1'b1, 2, 24'h0000FF, 1, 0, -1, 1'b0);   // R8 starved read
    chk(underrun_err == 1'b1, "R8 error raised", int'(underrun_err), 1);
    repeat (50) @(negedge clk);
    chk(underrun_err == 1'b1, "R8 error sticky", int'(underrun_err), 1);
    chk(rd_ready == 1'b0, "R7 ready low outside frame", int'(rd_ready), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule